// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Controller

This block is the single-thread decode stage of an out-of-order pipeline. Each cycle it receives a group of up to `FETCH_W` instructions from fetch and hands at most `DEC_W` of them to rename, in arrival order. Each instruction carries an opaque tag, a squashed flag and a source-register count. Instructions that cannot be forwarded are parked in a skid buffer. The buffer holds `F2D_LAT * FETCH_W + DEC_W` entries, which is enough to absorb what is already in flight from fetch while the stage tells fetch to stop.

Three downstream stages (rename, execute, commit) send block and unblock pulses, and the stage keeps one sticky stall flag per source. A five-state controller (Idle, Running, Blocked, Unblocking, Squashing) decides each cycle whether to forward, park, drain or discard. It sends one-cycle block and unblock pulses back to fetch. Commit can order a squash, and it can hold the stage in Squashing while its own flush is still in progress. All outputs are registered: the result of the inputs seen at a rising edge appears right after that edge.

Top module: `decode_skid_stage`

## Requirements
- R1: After synchronous reset, `stage_state` is Idle, with the codes Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4. `out_cnt`, `fetch_block`, `fetch_unblock`, `skid_cnt` and `skid_err` are all zero.
- R2: In Idle or Running with no stall, non-squashed inputs are forwarded in arrival order, at most `DEC_W` per cycle. Slot s occupies `out_tag[s*TAG_W +: TAG_W]`, and slots at or above `out_cnt` read zero.
- R3: In Idle or Running, inputs left unconsumed once `DEC_W` slots are filled go to the skid buffer. The state becomes Blocked with a `fetch_block` pulse.
- R4: The skid buffer holds `F2D_LAT*FETCH_W+DEC_W` entries. Arrivals that do not fit are discarded and set `skid_err`, which stays set until reset.
- R5: The decisions are taken in this order: commit squash, then commit busy, then any stall flag (block), then Blocked or Unblocking drains, then Squashing returns to Running.
- R6: `fetch_block` pulses only on a cycle where the state enters Blocked from another state. It is never high together with `fetch_unblock`.
- R7: While Blocked or Unblocking with no stall, up to `DEC_W` entries are forwarded from the skid buffer head, and new arrivals are appended behind the remaining entries.
- R8: Unblocking ends (state Running plus a `fetch_unblock` pulse) only in a cycle that leaves the skid buffer empty. Otherwise the state is Unblocking.
- R9: `cmt_squash` flushes the skid buffer, discards the inputs, forwards nothing and enters Squashing. It pulses `fetch_unblock` if the prior state was Blocked or Unblocking.
- R10: `cmt_busy` (without squash) keeps or enters Squashing, forwards nothing, discards the inputs and empties the skid buffer.
- R11: An instruction whose squashed flag (`in_sqz`) is set is consumed without being forwarded and uses no slot.
- R12: `out_rdy[s]` is set when forwarded slot s has a source count of zero.
- R13: Bits 0, 1 and 2 of `stall_set`/`stall_clr` belong to rename, execute and commit. Each flag is set by its set pulse and cleared by its clear pulse, and clear wins in the same cycle. The stage stalls while any flag is set.
- R14: From Squashing with no squash, busy or stall, the stage becomes Running and forwards that cycle's inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_cnt | input | $clog2(FETCH_W+1) | Number of valid instructions from fetch |
| in_tag | input | FETCH_W*TAG_W | Instruction tags, slot 0 in the low bits |
| in_nsrc | input | FETCH_W*SRC_W | Source-register counts |
| in_sqz | input | FETCH_W | Squashed flags |
| stall_set | input | 3 | Block pulses: bit0 rename, bit1 execute, bit2 commit |
| stall_clr | input | 3 | Unblock pulses, same bit order |
| cmt_squash | input | 1 | Squash order from commit |
| cmt_busy | input | 1 | Commit still flushing |
| out_cnt | output | $clog2(DEC_W+1) | Instructions forwarded to rename |
| out_tag | output | DEC_W*TAG_W | Forwarded tags |
| out_rdy | output | DEC_W | Ready-to-issue flag per slot |
| fetch_block | output | 1 | Block pulse to fetch |
| fetch_unblock | output | 1 | Unblock pulse to fetch |
| stage_state | output | 3 | Controller state code |
| skid_cnt | output | $clog2(SKID_D+1) | Skid buffer occupancy |
| skid_err | output | 1 | Sticky skid overflow flag |

## Verification
The hardest situation to reach from the ports is a long Unblocking phase, in which the buffer drains from its head while fresh arrivals keep landing behind it. The bench stacks two overlapping stall sources across several cycles so the buffer fills past the decode width. It then feeds new groups during the drain, so the state stays Unblocking until one exact cycle empties the buffer. Overflow is reached by holding a commit stall while fetch keeps sending full groups. A sweep over every group size and squash mask from Running then checks slot usage and the parking of leftovers.

// File: rtl/decode_skid_pkg.sv
package decode_skid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCKED = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } dstate_e;

    localparam int STALL_SRCS = 3;

endpackage

// File: rtl/dec_stall_flags.sv
module dec_stall_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic         any_o
);
    logic [N-1:0] flag_d, flag_q;

    // set first, clear afterwards: a clear in the same cycle wins
    always_comb begin
        flag_d = (flag_q | set_i) & ~clr_i;
        any_o  = |flag_d;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end
endmodule

// File: rtl/dec_slot_pick.sv
module dec_slot_pick #(
    parameter  int N     = 4,
    parameter  int W     = 4,
    parameter  int SRC_W = 3,
    parameter  int ENT_W = 20,
    localparam int AV_W  = $clog2(N + 1),
    localparam int OW    = $clog2(W + 1)
) (
    input  logic [N*ENT_W-1:0] ent_i,
    input  logic [AV_W-1:0]    avail_i,
    output logic [W*ENT_W-1:0] slot_o,
    output logic [W-1:0]       rdy_o,
    output logic [OW-1:0]      fwd_o,
    output logic [AV_W-1:0]    used_o
);
    logic [ENT_W-1:0] ent_a  [N];
    logic [ENT_W-1:0] slot_a [W];

    for (genvar i = 0; i < N; i++) begin : g_unpack
        assign ent_a[i] = ent_i[i*ENT_W +: ENT_W];
    end
    for (genvar s = 0; s < W; s++) begin : g_pack
        assign slot_o[s*ENT_W +: ENT_W] = slot_a[s];
    end

    // walk entries in order; squashed entries are consumed for free,
    // the scan stops once every slot is taken
    always_comb begin
        int  fwd;
        int  used;
        logic full;
        fwd  = 0;
        used = 0;
        full = 1'b0;
        rdy_o = '0;
        for (int s = 0; s < W; s++) slot_a[s] = '0;
        for (int i = 0; i < N; i++) begin
            if (i < int'(avail_i) && !full) begin
                if (fwd >= W) begin
                    full = 1'b1;
                end else begin
                    used = used + 1;
                    if (!ent_a[i][0]) begin
                        slot_a[fwd] = ent_a[i];
                        rdy_o[fwd]  = (ent_a[i][SRC_W:1] == '0);
                        fwd = fwd + 1;
                    end
                end
            end
        end
        fwd_o  = OW'(fwd);
        used_o = AV_W'(used);
    end
endmodule

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
    parameter  int DEPTH  = 12,
    parameter  int PUSH_W = 4,
    parameter  int ENT_W  = 20,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int PW     = $clog2(DEPTH),
    localparam int NW     = $clog2(PUSH_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush_i,
    input  logic [CW-1:0]           pop_n_i,
    input  logic [NW-1:0]           push_n_i,
    input  logic [PUSH_W*ENT_W-1:0] push_i,
    output logic [DEPTH*ENT_W-1:0]  win_o,
    output logic [CW-1:0]           cnt_o,
    output logic                    ovf_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PW-1:0]               head;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    // circular storage, next state: pop from head, then append behind
    always_comb begin
        int h;
        int c;
        int p;
        f_d   = f_q;
        ovf_o = 1'b0;
        h = 0;
        c = 0;
        p = 0;
        if (flush_i) begin
            f_d.head = '0;
            f_d.cnt  = '0;
        end else begin
            h = int'(f_q.head) + int'(pop_n_i);
            if (h >= DEPTH) h = h - DEPTH;
            c = int'(f_q.cnt) - int'(pop_n_i);
            for (int i = 0; i < PUSH_W; i++) begin
                if (i < int'(push_n_i)) begin
                    if (c < DEPTH) begin
                        p = h + c;
                        if (p >= DEPTH) p = p - DEPTH;
                        f_d.mem[p] = push_i[i*ENT_W +: ENT_W];
                        c = c + 1;
                    end else begin
                        ovf_o = 1'b1;
                    end
                end
            end
            f_d.head = PW'(h);
            f_d.cnt  = CW'(c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    // ordered view starting at the head
    always_comb begin
        int p;
        for (int i = 0; i < DEPTH; i++) begin
            p = int'(f_q.head) + i;
            if (p >= DEPTH) p = p - DEPTH;
            win_o[i*ENT_W +: ENT_W] = f_q.mem[p];
        end
    end

    assign cnt_o = f_q.cnt;
endmodule

// File: rtl/decode_skid_stage.sv
module decode_skid_stage
    import decode_skid_pkg::*;
#(
    parameter  int FETCH_W = 4,
    parameter  int DEC_W   = 4,
    parameter  int F2D_LAT = 2,
    parameter  int TAG_W   = 16,
    parameter  int SRC_W   = 3,
    localparam int SKID_D  = F2D_LAT * FETCH_W + DEC_W,
    localparam int ENT_W   = TAG_W + SRC_W + 1,
    localparam int FCNT_W  = $clog2(FETCH_W + 1),
    localparam int DCNT_W  = $clog2(DEC_W + 1),
    localparam int SCNT_W  = $clog2(SKID_D + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [FCNT_W-1:0]        in_cnt,
    input  logic [FETCH_W*TAG_W-1:0] in_tag,
    input  logic [FETCH_W*SRC_W-1:0] in_nsrc,
    input  logic [FETCH_W-1:0]       in_sqz,
    input  logic [STALL_SRCS-1:0]    stall_set,
    input  logic [STALL_SRCS-1:0]    stall_clr,
    input  logic                     cmt_squash,
    input  logic                     cmt_busy,
    output logic [DCNT_W-1:0]        out_cnt,
    output logic [DEC_W*TAG_W-1:0]   out_tag,
    output logic [DEC_W-1:0]         out_rdy,
    output logic                     fetch_block,
    output logic                     fetch_unblock,
    output logic [2:0]               stage_state,
    output logic [SCNT_W-1:0]        skid_cnt,
    output logic                     skid_err
);
    typedef struct packed {
        dstate_e                  st;
        logic [DCNT_W-1:0]        ocnt;
        logic [DEC_W*TAG_W-1:0]   otag;
        logic [DEC_W-1:0]         ordy;
        logic                     fblk;
        logic                     funb;
        logic                     err;
    } stage_t;

    stage_t r_d, r_q;

    // ---------------- incoming group ----------------
    logic [FETCH_W*ENT_W-1:0] in_ent;
    logic [ENT_W-1:0]         in_ent_a [FETCH_W];
    for (genvar i = 0; i < FETCH_W; i++) begin : g_in
        assign in_ent_a[i] = {in_tag[i*TAG_W +: TAG_W], in_nsrc[i*SRC_W +: SRC_W], in_sqz[i]};
        assign in_ent[i*ENT_W +: ENT_W] = in_ent_a[i];
    end

    // ---------------- stall flags ----------------
    logic any_stall;
    dec_stall_flags #(.N(STALL_SRCS)) i_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (stall_set),
        .clr_i (stall_clr),
        .any_o (any_stall)
    );

    // ---------------- pickers ----------------
    logic [DEC_W*ENT_W-1:0] f_slot, s_slot;
    logic [DEC_W-1:0]       f_rdy, s_rdy;
    logic [DCNT_W-1:0]      f_fwd, s_fwd;
    logic [FCNT_W-1:0]      f_used;
    logic [SCNT_W-1:0]      s_used;
    logic [SKID_D*ENT_W-1:0] sk_win;
    logic [SCNT_W-1:0]      sk_cnt;

    dec_slot_pick #(.N(FETCH_W), .W(DEC_W), .SRC_W(SRC_W), .ENT_W(ENT_W)) i_pick_fetch (
        .ent_i   (in_ent),
        .avail_i (in_cnt),
        .slot_o  (f_slot),
        .rdy_o   (f_rdy),
        .fwd_o   (f_fwd),
        .used_o  (f_used)
    );

    dec_slot_pick #(.N(SKID_D), .W(DEC_W), .SRC_W(SRC_W), .ENT_W(ENT_W)) i_pick_skid (
        .ent_i   (sk_win),
        .avail_i (sk_cnt),
        .slot_o  (s_slot),
        .rdy_o   (s_rdy),
        .fwd_o   (s_fwd),
        .used_o  (s_used)
    );

    // ---------------- skid buffer ----------------
    logic                     sk_flush;
    logic [SCNT_W-1:0]        sk_pop;
    logic [FCNT_W-1:0]        sk_push_n;
    logic [FETCH_W*ENT_W-1:0] sk_push;
    logic                     sk_ovf;
    int                       push_off;

    dec_skid_fifo #(.DEPTH(SKID_D), .PUSH_W(FETCH_W), .ENT_W(ENT_W)) i_skid (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (sk_flush),
        .pop_n_i  (sk_pop),
        .push_n_i (sk_push_n),
        .push_i   (sk_push),
        .win_o    (sk_win),
        .cnt_o    (sk_cnt),
        .ovf_o    (sk_ovf)
    );

    // leftovers of the incoming group, shifted down to slot 0
    always_comb begin
        int j;
        for (int i = 0; i < FETCH_W; i++) begin
            j = i + push_off;
            sk_push[i*ENT_W +: ENT_W] = (j < FETCH_W) ? in_ent_a[j] : '0;
        end
    end

    // ---------------- controller ----------------
    always_comb begin
        logic use_skid;
        logic fwd_en;
        logic [DEC_W*ENT_W-1:0] sel_slot;
        r_d       = r_q;
        r_d.ocnt  = '0;
        r_d.otag  = '0;
        r_d.ordy  = '0;
        r_d.fblk  = 1'b0;
        r_d.funb  = 1'b0;
        sk_flush  = 1'b0;
        sk_pop    = '0;
        sk_push_n = '0;
        push_off  = 0;
        use_skid  = 1'b0;
        fwd_en    = 1'b0;

        if (cmt_squash) begin
            r_d.st   = ST_SQUASH;
            r_d.funb = (r_q.st == ST_BLOCKED) || (r_q.st == ST_UNBLOCK);
            sk_flush = 1'b1;
        end else if (cmt_busy) begin
            r_d.st   = ST_SQUASH;
            sk_flush = 1'b1;
        end else if (any_stall) begin
            sk_push_n = in_cnt;
            if (r_q.st != ST_BLOCKED) begin
                r_d.st   = ST_BLOCKED;
                r_d.fblk = 1'b1;
            end
        end else if (r_q.st == ST_BLOCKED || r_q.st == ST_UNBLOCK) begin
            use_skid  = 1'b1;
            fwd_en    = 1'b1;
            sk_pop    = s_used;
            sk_push_n = in_cnt;
            if (s_used == sk_cnt && in_cnt == '0) begin
                r_d.st   = ST_RUN;
                r_d.funb = 1'b1;
            end else begin
                r_d.st   = ST_UNBLOCK;
            end
        end else begin
            fwd_en = 1'b1;
            if (r_q.st == ST_SQUASH) r_d.st = ST_RUN;
            if (f_used < in_cnt) begin
                push_off  = int'(f_used);
                sk_push_n = in_cnt - f_used;
                r_d.st    = ST_BLOCKED;
                r_d.fblk  = 1'b1;
            end
        end

        sel_slot = use_skid ? s_slot : f_slot;
        if (fwd_en) begin
            r_d.ocnt = use_skid ? s_fwd : f_fwd;
            r_d.ordy = use_skid ? s_rdy : f_rdy;
            for (int s = 0; s < DEC_W; s++) begin
                r_d.otag[s*TAG_W +: TAG_W] = sel_slot[s*ENT_W + SRC_W + 1 +: TAG_W];
            end
        end

        r_d.err = r_q.err | sk_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: ST_IDLE, default: '0};
        else     r_q <= r_d;
    end

    assign out_cnt       = r_q.ocnt;
    assign out_tag       = r_q.otag;
    assign out_rdy       = r_q.ordy;
    assign fetch_block   = r_q.fblk;
    assign fetch_unblock = r_q.funb;
    assign stage_state   = r_q.st;
    assign skid_cnt      = sk_cnt;
    assign skid_err      = r_q.err;
endmodule

// File: rtl/decode_skid_stage_chk.sv
module decode_skid_stage_chk
    import decode_skid_pkg::*;
#(
    parameter int DEC_W  = 4,
    parameter int SKID_D = 12,
    parameter int DCNT_W = 3,
    parameter int SCNT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmt_squash,
    input logic [DCNT_W-1:0] out_cnt,
    input logic              fetch_block,
    input logic              fetch_unblock,
    input logic [2:0]        stage_state,
    input logic [SCNT_W-1:0] skid_cnt,
    input logic              skid_err
);
    a_r2_width: assert property (@(posedge clk) disable iff (rst)
        int'(out_cnt) <= DEC_W);

    a_r4_capacity: assert property (@(posedge clk) disable iff (rst)
        int'(skid_cnt) <= SKID_D);

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
        skid_err |=> skid_err);

    a_r6_block_on_entry: assert property (@(posedge clk) disable iff (rst)
        fetch_block |-> (stage_state == ST_BLOCKED && $past(stage_state) != ST_BLOCKED));

    a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fetch_block && fetch_unblock));

    a_r8_unblock_empty: assert property (@(posedge clk) disable iff (rst)
        fetch_unblock |-> ((stage_state == ST_RUN && skid_cnt == '0) || stage_state == ST_SQUASH));

    a_r9_squash_flush: assert property (@(posedge clk) disable iff (rst)
        cmt_squash |=> (stage_state == ST_SQUASH && skid_cnt == '0 && out_cnt == '0));
endmodule

bind decode_skid_stage decode_skid_stage_chk #(
    .DEC_W  (DEC_W),
    .SKID_D (SKID_D),
    .DCNT_W (DCNT_W),
    .SCNT_W (SCNT_W)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .cmt_squash    (cmt_squash),
    .out_cnt       (out_cnt),
    .fetch_block   (fetch_block),
    .fetch_unblock (fetch_unblock),
    .stage_state   (stage_state),
    .skid_cnt      (skid_cnt),
    .skid_err      (skid_err)
);

// File: tb/test_decode_skid_stage.sv
module test_decode_skid_stage;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 4;
    localparam int DW = 2;
    localparam int TW = 8;
    localparam int SW = 2;
    localparam int ST_IDLE = 0, ST_RUN = 1, ST_BLK = 2, ST_UNB = 3, ST_SQ = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    in_cnt = '0;
    logic [FW*TW-1:0] in_tag = '0;
    logic [FW*SW-1:0] in_nsrc = '0;
    logic [FW-1:0] in_sqz = '0;
    logic [2:0]    stall_set = '0;
    logic [2:0]    stall_clr = '0;
    logic          cmt_squash = 1'b0;
    logic          cmt_busy = 1'b0;
    logic [1:0]    out_cnt;
    logic [DW*TW-1:0] out_tag;
    logic [DW-1:0] out_rdy;
    logic          fetch_block, fetch_unblock;
    logic [2:0]    stage_state;
    logic [2:0]    skid_cnt;
    logic          skid_err;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decode_skid_stage #(.FETCH_W(FW), .DEC_W(DW), .F2D_LAT(1), .TAG_W(TW), .SRC_W(SW))
    i_decode_skid_stage (
        .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_tag(in_tag), .in_nsrc(in_nsrc),
        .in_sqz(in_sqz), .stall_set(stall_set), .stall_clr(stall_clr),
        .cmt_squash(cmt_squash), .cmt_busy(cmt_busy), .out_cnt(out_cnt),
        .out_tag(out_tag), .out_rdy(out_rdy), .fetch_block(fetch_block),
        .fetch_unblock(fetch_unblock), .stage_state(stage_state),
        .skid_cnt(skid_cnt), .skid_err(skid_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // zmask bit set = zero sources; otherwise one source
    task automatic put(input int n, input int t0, input int t1, input int t2, input int t3,
                       input logic [3:0] sq, input logic [3:0] zmask);
        in_cnt = 3'(n);
        in_tag = {TW'(t3), TW'(t2), TW'(t1), TW'(t0)};
        in_sqz = sq;
        for (int i = 0; i < FW; i++) in_nsrc[i*SW +: SW] = zmask[i] ? 2'd0 : 2'd1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        in_cnt = '0; in_tag = '0; in_sqz = '0; in_nsrc = '0;
        stall_set = '0; stall_clr = '0; cmt_squash = 1'b0; cmt_busy = 1'b0;
    endtask

    function automatic int slot(input int s);
        return int'(out_tag[s*TW +: TW]);
    endfunction

    task automatic expect_out(input string req, input int n, input int ta, input int tb,
                              input int st, input int sk);
        chk({req, " out_cnt"}, int'(out_cnt), n);
        if (n > 0) chk({req, " slot0"}, slot(0), ta);
        if (n > 1) chk({req, " slot1"}, slot(1), tb);
        if (n < 2) chk({req, " unused slot1 zero"}, slot(1), 0);
        chk({req, " state"}, int'(stage_state), st);
        chk({req, " skid_cnt"}, int'(skid_cnt), sk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1 state", int'(stage_state), ST_IDLE);
        chk("R1 out_cnt", int'(out_cnt), 0);
        chk("R1 skid_cnt", int'(skid_cnt), 0);
        chk("R1 skid_err", int'(skid_err), 0);
        chk("R1 pulses", int'({fetch_block, fetch_unblock}), 0);

        // R2 R12: idle forwards two, second has zero sources
        put(2, 10, 11, 0, 0, 4'b0000, 4'b0010); step();
        expect_out("R2", 2, 10, 11, ST_IDLE, 0);
        chk("R12 ready flags", int'(out_rdy), 2);

        // R3: four arrive, two park
        put(4, 20, 21, 22, 23, 4'b0000, 4'b0000); step();
        expect_out("R3", 2, 20, 21, ST_BLK, 2);
        chk("R3 block pulse", int'(fetch_block), 1);

        // R7 R8: drained in one cycle, back to running
        step();
        expect_out("R8 drain", 2, 22, 23, ST_RUN, 0);
        chk("R8 unblock pulse", int'(fetch_unblock), 1);
        chk("R6 no repeat block", int'(fetch_block), 0);

        // R11: squashed entries use no slot
        put(4, 90, 30, 91, 31, 4'b0101, 4'b0000); step();
        expect_out("R11", 2, 30, 31, ST_RUN, 0);

        // R13 R5: rename stall parks the arrival
        stall_set = 3'b001; put(1, 40, 0, 0, 0, 4'b0, 4'b0); step();
        expect_out("R13 rename stall", 0, 0, 0, ST_BLK, 1);
        chk("R6 block entry pulse", int'(fetch_block), 1);

        stall_set = 3'b001; put(2, 41, 42, 0, 0, 4'b0, 4'b0); step();
        expect_out("R6 repeated stall", 0, 0, 0, ST_BLK, 3);
        chk("R6 no second pulse", int'(fetch_block), 0);

        stall_set = 3'b010; stall_clr = 3'b001; put(1, 43, 0, 0, 0, 4'b0, 4'b0); step();
        expect_out("R13 execute still stalls", 0, 0, 0, ST_BLK, 4);

        stall_clr = 3'b010; put(3, 44, 45, 46, 0, 4'b0, 4'b0); step();
        expect_out("R7 drain with arrivals", 2, 40, 41, ST_UNB, 5);
        chk("R8 no early unblock", int'(fetch_unblock), 0);

        step();
        expect_out("R7 drain", 2, 42, 43, ST_UNB, 3);
        put(4, 47, 48, 49, 50, 4'b0, 4'b0); step();
        expect_out("R7 append", 2, 44, 45, ST_UNB, 5);
        step();
        expect_out("R7 order", 2, 46, 47, ST_UNB, 3);
        step();
        expect_out("R7 order2", 2, 48, 49, ST_UNB, 1);
        step();
        expect_out("R8 done", 1, 50, 0, ST_RUN, 0);
        chk("R8 unblock pulse late", int'(fetch_unblock), 1);

        // R13: set and clear together leaves no stall
        stall_set = 3'b100; stall_clr = 3'b100; put(1, 55, 0, 0, 0, 4'b0, 4'b0); step();
        expect_out("R13 clear wins", 1, 55, 0, ST_RUN, 0);

        // R4: overflow under commit stall
        stall_set = 3'b100; put(4, 60, 61, 62, 63, 4'b0, 4'b0); step();
        expect_out("R4 fill", 0, 0, 0, ST_BLK, 4);
        put(4, 64, 65, 66, 67, 4'b0, 4'b0); step();
        expect_out("R4 full", 0, 0, 0, ST_BLK, 6);
        chk("R4 err set", int'(skid_err), 1);
        put(2, 68, 69, 0, 0, 4'b0, 4'b0); step();
        chk("R4 stays full", int'(skid_cnt), 6);

        // R9: squash from blocked
        cmt_squash = 1'b1; stall_clr = 3'b100; put(2, 1, 2, 0, 0, 4'b0, 4'b0); step();
        expect_out("R9 squash", 0, 0, 0, ST_SQ, 0);
        chk("R9 unblock pulse", int'(fetch_unblock), 1);
        chk("R4 err sticky", int'(skid_err), 1);

        // R10: busy discards
        cmt_busy = 1'b1; put(2, 70, 71, 0, 0, 4'b0, 4'b0); step();
        expect_out("R10 busy", 0, 0, 0, ST_SQ, 0);
        chk("R10 no pulse", int'(fetch_unblock), 0);

        // R14: back to running and forwarding at once
        put(2, 72, 73, 0, 0, 4'b0, 4'b0); step();
        expect_out("R14 resume", 2, 72, 73, ST_RUN, 0);

        // R5: squash beats a stall in the same cycle
        stall_set = 3'b001; cmt_squash = 1'b1; put(1, 74, 0, 0, 0, 4'b0, 4'b0); step();
        expect_out("R5 squash first", 0, 0, 0, ST_SQ, 0);
        chk("R5 no block pulse", int'(fetch_block), 0);
        chk("R9 no unblock from running", int'(fetch_unblock), 0);
        step();
        expect_out("R5 stall next", 0, 0, 0, ST_BLK, 0);
        chk("R5 block pulse", int'(fetch_block), 1);
        stall_clr = 3'b001; step();
        expect_out("R8 empty unblock", 0, 0, 0, ST_RUN, 0);
        chk("R8 pulse empty", int'(fetch_unblock), 1);

        // sweep R2 R3 R11: every group size and squash mask from running
        for (int n = 0; n <= FW; n++) begin
            for (int m = 0; m < 16; m++) begin
                int f;
                int used;
                int first;
                f = 0; used = 0; first = -1;
                for (int i = 0; i < n; i++) begin
                    if (f == DW) break;
                    used++;
                    if (!m[i]) begin
                        if (first < 0) first = 128 + i;
                        f++;
                    end
                end
                put(n, 128, 129, 130, 131, 4'(m), 4'b0);
                step();
                chk("R2 sweep count", int'(out_cnt), f);
                if (f > 0) chk("R11 sweep first", slot(0), first);
                chk("R3 sweep skid", int'(skid_cnt), n - used);
                chk("R3 sweep state", int'(stage_state), (used < n) ? ST_BLK : ST_RUN);
                chk("R3 sweep pulse", int'(fetch_block), (used < n) ? 1 : 0);
                if (used < n) begin
                    step();
                    chk("R8 sweep recover", int'(stage_state), ST_RUN);
                    chk("R8 sweep pulse", int'(fetch_unblock), 1);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule